// File: doc/BRIEF.md
# ADC Result Register Interface

This block is the bus-side digital front end of a 10-bit analog-to-digital converter. It sits between an 8-bit CPU bus and the conversion engine. It divides the system clock by a selectable power of two to produce a converter clock-enable pulse. It captures each 10-bit result when the engine strobes completion, and it keeps a completion flag that can raise an interrupt.

Software reads the result through two read-only byte registers. A control bit selects whether the value is right-adjusted (low byte full) or left-adjusted (high byte full). A read of the low byte freezes the held result until the high byte is read, so a two-byte read always returns one coherent sample. A program that needs only 8 bits uses left-adjusted layout and reads the high byte alone, which does not freeze anything.

Register map: address 0 is the result low byte, address 1 is the result high byte, and address 2 is control. The control bits are: [7] converter enable, [6] interrupt enable, [5] completion flag (write 1 to clear), [4] left-adjust, [3] reads 0, and [2:0] prescaler select.

Top module: `adc_result_if`

## Requirements
- R1: After reset, both result bytes and the control register read 0x00 and irq_o is low.
- R2: With left-adjust clear, address 0 returns result[7:0] and address 1 returns {6'b0, result[9:8]}.
- R3: With left-adjust set, address 1 returns result[9:2] and address 0 returns {result[1:0], 6'b0}.
- R4: A read of address 0 locks the held result. A completion that arrives while locked, or in the same cycle as the low read, is discarded. The lock releases on the clock edge that samples a read of address 1.
- R5: A read of address 1 with no lock in place does not lock, so later results still update the registers.
- R6: The select codes 0 through 7 give a tick_o period of 2, 2, 4, 8, 16, 32, 64 and 128 system clocks. With enable just set, the first tick comes after period-1 cycles.
- R7: While enable (control bit 7) is 0, the prescaler counter is held at zero and tick_o stays low. Each tick lasts one cycle.
- R8: Every completion strobe sets the flag (control bit 5), including one whose result is discarded.
- R9: The flag is cleared by a control write with bit 5 at 1, or by an irq_ack_i pulse. A control write with bit 5 at 0 leaves it set.
- R10: irq_o is high only while the flag, the interrupt enable (control bit 6) and gie_i are all set.
- R11: Changing left-adjust re-maps the held result in both bytes at once, with no new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, same cycle |
| conv_done_i | input | 1 | Conversion complete strobe |
| conv_result_i | input | 10 | Conversion result |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| conv_tick_o | output | 1 | Converter clock-enable pulse |
| irq_o | output | 1 | Conversion complete interrupt |

## Verification
The assertions check on every cycle that the held result cannot change while locked, that a low read engages the lock and an unlocked high read does not, that a completion is captured when it is allowed, that the flag sets and acknowledge clears it, and that the prescaler stays idle when disabled and emits single-cycle ticks. Only the bench scenarios can show the byte layouts in both adjust modes, the immediate re-map on a mode change, and the exact tick period for each select code. The same applies to discarded results during a two-byte read and to the gating of the interrupt by each enable.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam int BIT_EN   = 7;
  localparam int BIT_IE   = 6;
  localparam int BIT_DONE = 5;
  localparam int BIT_LEFT = 4;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // code 0 aliases divide by 2
  always_comb begin
    if (sel_i == '0) lim = CNT_W'(1);
    else             lim = CNT_W'((32'd1 << sel_i) - 32'd1);
  end

  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  p_tick_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  input  logic             left_i,
  output logic [BUS_W-1:0] lo_o,
  output logic [BUS_W-1:0] hi_o
);
  localparam int PAD_W = 2 * BUS_W - RES_W;

  logic [RES_W-1:0]   res_q;
  logic               lock_q;
  logic               take;
  logic [2*BUS_W-1:0] word;

  // a low read in the same cycle as a completion also blocks it
  assign take = conv_done_i && !lock_q && !rd_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (take) res_q <= conv_result_i;
      if (rd_lo_i)      lock_q <= 1'b1;
      else if (rd_hi_i) lock_q <= 1'b0;
    end
  end

  assign word = left_i ? {res_q, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, res_q};
  assign hi_o = word[2*BUS_W-1:BUS_W];
  assign lo_o = word[BUS_W-1:0];

  p_lock_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(res_q));
  p_lo_locks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> lock_q);
  p_hi_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !lock_q) |=> !lock_q);
  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !lock_q && !rd_lo_i) |=> (res_q == $past(conv_result_i)));
endmodule

// File: rtl/adc_irq_flag.sv
module adc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic ack_i,
  input  logic ie_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // a new completion wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (set_i)              flag_q <= 1'b1;
    else if (clr_wr_i || ack_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i && gie_i;

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !irq_o);
  p_wr_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/adc_result_if.sv
module adc_result_if
  import adc_if_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  output logic             conv_tick_o,
  output logic             irq_o
);
  logic             en_q, ie_q, left_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_ctrl, rd_lo, rd_hi, flag;
  logic [BUS_W-1:0] lo_b, hi_b, ctrl_b;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign rd_lo   = rd_i && (addr_i == ADDR_LO);
  assign rd_hi   = rd_i && (addr_i == ADDR_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      left_q <= 1'b0;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[BIT_EN];
      ie_q   <= wdata_i[BIT_IE];
      left_q <= wdata_i[BIT_LEFT];
      sel_q  <= wdata_i[SEL_W-1:0];
    end
  end

  always_comb begin
    ctrl_b              = '0;
    ctrl_b[BIT_EN]      = en_q;
    ctrl_b[BIT_IE]      = ie_q;
    ctrl_b[BIT_DONE]    = flag;
    ctrl_b[BIT_LEFT]    = left_q;
    ctrl_b[SEL_W-1:0]   = sel_q;
  end

  always_comb begin
    case (addr_i)
      ADDR_LO:   rdata_o = lo_b;
      ADDR_HI:   rdata_o = hi_b;
      ADDR_CTRL: rdata_o = ctrl_b;
      default:   rdata_o = '0;
    endcase
  end

  adc_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .sel_i  (sel_q),
    .tick_o (conv_tick_o)
  );

  adc_result_hold #(.RES_W(RES_W), .BUS_W(BUS_W)) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .conv_done_i   (conv_done_i),
    .conv_result_i (conv_result_i),
    .rd_lo_i       (rd_lo),
    .rd_hi_i       (rd_hi),
    .left_i        (left_q),
    .lo_o          (lo_b),
    .hi_o          (hi_b)
  );

  adc_irq_flag u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (conv_done_i),
    .clr_wr_i (wr_ctrl && wdata_i[BIT_DONE]),
    .ack_i    (irq_ack_i),
    .ie_i     (ie_q),
    .gie_i    (gie_i),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );
endmodule

// File: tb/adc_result_if_tb.sv
module adc_result_if_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       done = 1'b0;
  logic [9:0] result = '0;
  logic       gie = 1'b0, ack = 1'b0;
  logic       tick, irq;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  adc_result_if u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .conv_done_i(done),
    .conv_result_i(result), .gie_i(gie), .irq_ack_i(ack),
    .conv_tick_o(tick), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic conv(input logic [9:0] v);
    @(negedge clk); result = v; done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(2'd0, d); check("R1 lo", d, 8'h00);
    bus_rd(2'd1, d); check("R1 hi", d, 8'h00);
    bus_rd(2'd2, d); check("R1 ctrl", d, 8'h00);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    bus_wr(2'd2, 8'h00);
    conv(10'h2A5);
    bus_rd(2'd0, d); check("R2 lo", d, 8'hA5);
    bus_rd(2'd1, d); check("R2 hi", d, 8'h02);
    bus_wr(2'd2, 8'h10);
    bus_rd(2'd0, d); check("R3 lo", d, 8'h40);
    bus_rd(2'd1, d); check("R3 hi", d, 8'hA9);
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd0, d); check("R11 lo remap", d, 8'hA5);
    bus_rd(2'd1, d); check("R11 hi remap", d, 8'h02);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    conv(10'h155);
    bus_rd(2'd0, d); check("R4 lo first", d, 8'h55);
    bus_wr(2'd2, 8'h20);
    conv(10'h3FF);
    bus_rd(2'd2, d); check("R8 flag on discard", (d >> 5) & 1, 1);
    bus_rd(2'd1, d); check("R4 hi held", d, 8'h01);
    bus_rd(2'd0, d); check("R4 lo held", d, 8'h55);
    bus_rd(2'd1, d); check("R4 hi unlock", d, 8'h01);
    conv(10'h0F0);
    bus_rd(2'd0, d); check("R4 lo after unlock", d, 8'hF0);
    bus_rd(2'd1, d); check("R4 hi after unlock", d, 8'h00);
  endtask

  task automatic t_hi_only();
    logic [7:0] d;
    bus_wr(2'd2, 8'h10);
    conv(10'h3FC);
    bus_rd(2'd1, d); check("R5 hi first", d, 8'hFF);
    conv(10'h004);
    bus_rd(2'd1, d); check("R5 hi updated", d, 8'h01);
    bus_rd(2'd0, d); check("R3 lo zero bits", d, 8'h00);
    bus_rd(2'd1, d);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    bus_wr(2'd2, 8'h20);
    bus_rd(2'd2, d); check("R9 clear by w1", (d >> 5) & 1, 0);
    conv(10'h001);
    bus_rd(2'd2, d); check("R8 flag set", (d >> 5) & 1, 1);
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd2, d); check("R9 w0 keeps", (d >> 5) & 1, 1);
    bus_wr(2'd2, 8'h20);
    bus_rd(2'd2, d); check("R9 w1 clears", (d >> 5) & 1, 0);
    conv(10'h002);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    bus_rd(2'd2, d); check("R9 ack clears", (d >> 5) & 1, 0);
  endtask

  task automatic t_irq();
    bus_wr(2'd2, 8'h00);
    conv(10'h010);
    gie = 1'b1; #1 check("R10 ie off", irq, 0);
    bus_wr(2'd2, 8'h40);
    gie = 1'b0; #1 check("R10 gie off", irq, 0);
    gie = 1'b1; #1 check("R10 both on", irq, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R10 after ack", irq, 0);
    gie = 1'b0;
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_presc();
    for (int s = 0; s < 8; s++) begin
      int cnt = 0;
      int dbl = 0;
      logic prev = 1'b0;
      int div = (s == 0) ? 2 : (1 << s);
      bus_wr(2'd2, 8'(s));
      for (int i = 0; i < 40; i++) begin
        cnt += tick; @(negedge clk);
      end
      check("R7 idle no tick", cnt, 0);
      cnt = 0;
      bus_wr(2'd2, 8'h80 | 8'(s));
      for (int i = 0; i < 256; i++) begin
        cnt += tick;
        if (prev && tick) dbl++;
        prev = tick;
        @(negedge clk);
      end
      check("R6 tick count", cnt, 256 / div);
      check("R7 single cycle", dbl, 0);
      bus_wr(2'd2, 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_layout();
    t_lock();
    t_hi_only();
    t_flag();
    t_irq();
    t_presc();
    summary();
    $finish;
  end
endmodule